// File: doc/BRIEF.md
# SIMD Lane-wise Concatenation Unit

This block joins two packed SIMD operands into one wider packed result, one lane at a time. Operand A is 16 bits and operand B is 32 bits. Both operands are treated as four base granules (4-bit granules for A, 8-bit granules for B). These granules are grouped into one, two or four lanes, as chosen at run time by a 2-bit element-width code.

Each output lane holds the A part of that lane in its least-significant bits and the B part of the same lane directly above it. Output lanes are stacked from least to most significant in the same order as the input lanes, so the 48-bit result is always completely filled. The block has no clock. The result follows any change on the operands or the code combinationally, which lets it sit inside a datapath stage of a partitioned execution unit.

Top module: `simd_lane_cat`

## Requirements
- R1: With element-width code 2'b00 the result is the flat join {B, A}: A in bits 15:0 and B in bits 47:16.
- R2: With code 2'b01 there are two 24-bit lanes. Lane 0 (bits 23:0) is {B[15:0], A[7:0]} and lane 1 (bits 47:24) is {B[31:16], A[15:8]}.
- R3: With code 2'b10 there are four 12-bit lanes. Lane k, in bits 12k+11:12k, is {B[8k+7:8k], A[4k+3:4k]} for k = 0..3.
- R4: The spare code 2'b11 gives exactly the same result as code 2'b00, so the output is always defined.
- R5: The result follows a change of any operand or of the code with no clock edge.
- R6: Every operand bit appears exactly once in the result, so the number of set bits in the result equals the number of set bits in A plus the number in B, for every code.
- R7: The result is correct for every code on these operand pairs: all-zero, A=0xDCBA with B=0x12345678, A=0xFFFF with B=0, and A=0 with B=0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ew_code | input | 2 | Element-width code selecting one, two or four lanes |
| opnd_a | input | 16 | Packed operand that forms the low part of each lane |
| opnd_b | input | 32 | Packed operand that forms the high part of each lane |
| cat_y | output | 48 | Lane-wise joined result |

## Verification
The bench targets the points where a lane layout goes wrong. Granule order is one: if A and B were swapped inside a lane, the nibble and byte patterns of 0xDCBA and 0x12345678 would show up in the wrong positions. Lane boundaries are another: a design that flattened the two-lane case to {B, A} would put A[15:8] in bits 15:8 instead of bits 31:24. The spare code 11 is checked against the single-lane result, so a decoder that leaves it unmatched would produce zero. The all-ones operand patterns make a dropped or duplicated granule visible as a wrong count of set bits. Operand changes made between clock edges show that the result does not wait for a clock.

// File: rtl/simd_cat_pkg.sv
package simd_cat_pkg;
  // number of base granules each operand is cut into
  parameter int GRAN_N = 4;
  // granule widths of the two operands
  parameter int A_GW   = 4;
  parameter int B_GW   = 8;
  // width of the element-width code
  parameter int EW_W   = 2;

  localparam int A_W   = GRAN_N * A_GW;
  localparam int B_W   = GRAN_N * B_GW;
  localparam int O_W   = A_W + B_W;
  // lane-count variants: 1, 2, 4 ... GRAN_N lanes
  localparam int NV    = $clog2(GRAN_N) + 1;
endpackage

// File: rtl/simd_cat_mode_dec.sv
module simd_cat_mode_dec
  import simd_cat_pkg::*;
#(
  parameter int CODE_W = EW_W,
  parameter int N_VAR  = NV
) (
  input  logic [CODE_W-1:0] ew_code,
  output logic [N_VAR-1:0]  var_sel
);
  logic hit;

  // code v selects the 2^v-lane variant; unused codes fall back to one lane
  always_comb begin
    var_sel = '0;
    hit     = 1'b0;
    for (int v = 0; v < N_VAR; v++) begin
      if (int'(ew_code) == v) begin
        var_sel[v] = 1'b1;
        hit        = 1'b1;
      end
    end
    if (!hit) var_sel[0] = 1'b1;
  end
endmodule

// File: rtl/simd_cat_layout.sv
module simd_cat_layout
  import simd_cat_pkg::*;
#(
  parameter int LANES = 1,
  parameter int GN    = GRAN_N,
  parameter int AG    = A_GW,
  parameter int BG    = B_GW
) (
  input  logic [GN*AG-1:0]      a_in,
  input  logic [GN*BG-1:0]      b_in,
  output logic [GN*(AG+BG)-1:0] y_out
);
  // granules per lane and width of one output lane
  localparam int GPL    = GN / LANES;
  localparam int LANE_W = GPL * (AG + BG);

  for (genvar g = 0; g < GN; g++) begin : g_gran
    localparam int K     = g / GPL;
    localparam int J     = g % GPL;
    localparam int A_POS = K * LANE_W + J * AG;
    localparam int B_POS = K * LANE_W + GPL * AG + J * BG;
    assign y_out[A_POS +: AG] = a_in[g*AG +: AG];
    assign y_out[B_POS +: BG] = b_in[g*BG +: BG];
  end
endmodule

// File: rtl/simd_cat_select.sv
module simd_cat_select
  import simd_cat_pkg::*;
#(
  parameter int N_VAR = NV,
  parameter int W     = O_W
) (
  input  logic [N_VAR-1:0][W-1:0] cand,
  input  logic [N_VAR-1:0]        var_sel,
  output logic [W-1:0]            y
);
  always_comb begin
    y = '0;
    for (int v = 0; v < N_VAR; v++) begin
      y = y | (cand[v] & {W{var_sel[v]}});
    end
  end
endmodule

// File: rtl/simd_lane_cat.sv
module simd_lane_cat
  import simd_cat_pkg::*;
(
  input  logic [EW_W-1:0] ew_code,
  input  logic [A_W-1:0]  opnd_a,
  input  logic [B_W-1:0]  opnd_b,
  output logic [O_W-1:0]  cat_y
);
  logic [NV-1:0]          var_sel;
  logic [NV-1:0][O_W-1:0] cand;

  simd_cat_mode_dec #(.CODE_W(EW_W), .N_VAR(NV)) u_dec (
    .ew_code (ew_code),
    .var_sel (var_sel)
  );

  // one fixed wiring per lane count, picked by the decoded code
  for (genvar v = 0; v < NV; v++) begin : g_var
    simd_cat_layout #(.LANES(1 << v), .GN(GRAN_N), .AG(A_GW), .BG(B_GW)) u_lay (
      .a_in  (opnd_a),
      .b_in  (opnd_b),
      .y_out (cand[v])
    );
  end

  simd_cat_select #(.N_VAR(NV), .W(O_W)) u_sel (
    .cand    (cand),
    .var_sel (var_sel),
    .y       (cat_y)
  );
endmodule

// File: rtl/simd_lane_cat_chk.sv
module simd_lane_cat_chk
  import simd_cat_pkg::*;
(
  input logic [EW_W-1:0] ew_code,
  input logic [A_W-1:0]  opnd_a,
  input logic [B_W-1:0]  opnd_b,
  input logic [O_W-1:0]  cat_y
);
  always_comb begin
    // R1
    if (ew_code == 2'b00) begin
      one_lane_chk: assert (cat_y == {opnd_b, opnd_a});
    end
    // R4
    if (ew_code == 2'b11) begin
      spare_code_chk: assert (cat_y == {opnd_b, opnd_a});
    end
    // R3
    if (ew_code == 2'b10) begin
      for (int g = 0; g < GRAN_N; g++) begin
        fine_lane_chk: assert (cat_y[g*(A_GW+B_GW) +: (A_GW+B_GW)]
                               == {opnd_b[g*B_GW +: B_GW], opnd_a[g*A_GW +: A_GW]});
      end
    end
    // R6
    bit_count_chk: assert ($countones(cat_y) == $countones(opnd_a) + $countones(opnd_b));
  end
endmodule

bind simd_lane_cat simd_lane_cat_chk u_chk (
  .ew_code (ew_code),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .cat_y   (cat_y)
);

// File: tb/tb_simd_lane_cat.sv
module tb_simd_lane_cat;
  logic        clk = 1'b0;
  logic [1:0]  ew_code;
  logic [15:0] opnd_a;
  logic [31:0] opnd_b;
  logic [47:0] cat_y;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  simd_lane_cat dut (
    .ew_code (ew_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .cat_y   (cat_y)
  );

  // software lane model: lanes filled A part first, then B part
  function automatic logic [47:0] ref_cat(input logic [1:0] code,
                                          input logic [15:0] a,
                                          input logic [31:0] b);
    int lanes, aw, bw, pos;
    logic [47:0] y;
    lanes = (code == 2'b01) ? 2 : (code == 2'b10) ? 4 : 1;
    aw = 16 / lanes;
    bw = 32 / lanes;
    y = '0;
    pos = 0;
    for (int k = 0; k < lanes; k++) begin
      for (int i = 0; i < aw; i++) y[pos + i] = a[k*aw + i];
      pos += aw;
      for (int i = 0; i < bw; i++) y[pos + i] = b[k*bw + i];
      pos += bw;
    end
    return y;
  endfunction

  task automatic check(input string req, input logic [47:0] exp);
    tests++;
    if (cat_y !== exp) begin
      fails++;
      $display("FAIL %s code=%b a=%h b=%h got=%h exp=%h", req, ew_code, opnd_a, opnd_b, cat_y, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [15:0] a, input logic [31:0] b);
    @(negedge clk);
    ew_code = c; opnd_a = a; opnd_b = b;
    #1;
  endtask

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  logic [15:0] pa [7] = '{16'h0000, 16'hDCBA, 16'hABCD, 16'hFFFF, 16'h0000, 16'h1F1F, 16'h0000};
  logic [31:0] pb [7] = '{32'h0, 32'h12345678, 32'h01234567, 32'h0, 32'h0, 32'hF1F1F1F1, 32'hFFFFFFFF};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    ew_code = 2'b00; opnd_a = '0; opnd_b = '0;
    #1;
    // idle state: zero operands give zero result (R7)
    check("R7", 48'h0);

    // R1 R2 R3 R4 R7: every code with every operand pair
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 7; p++) begin
        apply(2'(c), pa[p], pb[p]);
        check(req_of(2'(c)), ref_cat(2'(c), pa[p], pb[p]));
        check("R7", ref_cat(2'(c), pa[p], pb[p]));
      end
    end

    // hand-worked values
    apply(2'b10, 16'hDCBA, 32'h12345678);
    check("R3", 48'h12D_34C_56B_78A);
    apply(2'b01, 16'hDCBA, 32'h12345678);
    check("R2", 48'h1234DC_5678BA);
    apply(2'b11, 16'hDCBA, 32'h12345678);
    check("R4", 48'h12345678DCBA);

    // R6: set-bit count preserved for every code
    for (int c = 0; c < 4; c++) begin
      apply(2'(c), 16'hA5C3, 32'h0F0F3C81);
      tests++;
      if ($countones(cat_y) != $countones(opnd_a) + $countones(opnd_b)) begin
        fails++;
        $display("FAIL R6 code=%0d got=%0d exp=%0d", c, $countones(cat_y),
                 $countones(opnd_a) + $countones(opnd_b));
      end
    end

    // R5: changes between clock edges reach the output without a clock edge
    @(posedge clk);
    #0.5;
    opnd_a = 16'h1234; opnd_b = 32'hCAFEBEEF; ew_code = 2'b10;
    #0.5;
    check("R5", ref_cat(2'b10, 16'h1234, 32'hCAFEBEEF));
    ew_code = 2'b01;
    #0.5;
    check("R5", ref_cat(2'b01, 16'h1234, 32'hCAFEBEEF));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule